// File: doc/BRIEF.md
# Binary-Search Reciprocal Unit

This block produces the fixed-point fraction nearest to, but not above, 1/v for an unsigned N-bit operand v. The result is an N-bit fraction whose weight is 2^-N per LSB. The block finds it one result bit per clock, by binary search from the most significant fraction bit down. It does not multiply on every step. Instead it keeps the running product of the current approximation and the operand in a register that is 2N+1 bits wide. Each trial bit then costs one addition of the operand shifted to that bit's position, followed by one compare against the constant that stands for one (2^N). A trial bit is kept only when the trial product does not exceed that constant.

A caller pulses `start` with the operand on `value_in` while the unit is idle. `busy` is high for exactly N cycles. Then `done` pulses for one cycle. From that point `recip_out` and `zero_seen` hold their values until the next accepted start. An operand of zero passes every trial, so its result is all ones, and the unit also raises `zero_seen`.

Top module: `recip_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `zero_seen` and `recip_out` are all 0.
- R2: A `start` seen at a clock edge while `busy` and `done` are both low is accepted. `busy` is then high for exactly N consecutive cycles starting with the next cycle.
- R3: `done` is high for exactly one cycle, namely the cycle right after the last `busy` cycle. `done` and `busy` are never high together.
- R4: For a nonzero operand v, the result while `done` is high equals min(floor(2^N / v), 2^N - 1). This is the largest N-bit x with x*v <= 2^N.
- R5: The equality case counts as passing. For v = 2^m with 1 <= m <= N-1 the result is exactly 2^(N-m), and for v = 1 the result is all ones.
- R6: For v = 0 the result is all ones and `zero_seen` is 1. For any nonzero v, `zero_seen` is 0 when `done` is high.
- R7: A `start` that arrives while `busy` or `done` is high has no effect. The operand in flight, the timing of `done` and the result are unchanged, and no new run begins after `done`.
- R8: When the unit is idle, `recip_out` and `zero_seen` stay unchanged whatever `value_in` does, until the next accepted start.
- R9: The internal running product never exceeds 2^N, and `recip_out` times the operand never exceeds 2^N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a reciprocal of `value_in`; honoured only when idle |
| value_in | input | N | Unsigned operand, captured at the accepted start |
| busy | output | 1 | High during the N search cycles |
| done | output | 1 | One-cycle pulse when the result is final |
| recip_out | output | N | Reciprocal fraction, LSB weight 2^-N |
| zero_seen | output | 1 | Captured operand was zero |

## Verification
If the trial-bit index, the running product or the accept decision goes wrong inside, the error shows up at the ports when `done` rises, N+1 cycles after the start. It appears as a result that breaks x*v <= 2^N < (x+1)*v. A mistake in the sequencer shows up sooner, as `busy` lasting a cycle too long or too short, or as a second `done`. All 2^N operands are swept with exact expected results, so one wrong product bit is caught for every operand it affects. Separate directed runs check that the unit ignores new operands while a run is in flight and holds its result afterwards.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } recip_state_e;

    // Width of an index that counts 0..n-1 (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width of the running product: approx*v plus one shifted operand.
    function automatic int unsigned prod_width(input int unsigned n);
        return 2 * n + 1;
    endfunction

endpackage

// File: rtl/recip_ctrl.sv
module recip_ctrl
    import recip_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned KW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          step,
    output logic [KW-1:0] bit_idx
);
    localparam logic [KW-1:0] TOP_IDX = KW'(N - 1);

    recip_state_e state_q;
    logic [KW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        idx_q   <= TOP_IDX;
                    end
                end
                ST_RUN: begin
                    if (idx_q == '0) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q == ST_RUN);
        done    = (state_q == ST_FIN);
        load    = (state_q == ST_IDLE) && start;
        step    = (state_q == ST_RUN);
        bit_idx = idx_q;
    end

endmodule

// File: rtl/recip_step.sv
module recip_step
    import recip_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned KW = idx_width(N),
    parameter int unsigned PW = prod_width(N)
) (
    input  logic [N-1:0]  operand,
    input  logic [PW-1:0] prod,
    input  logic [KW-1:0] bit_idx,
    output logic [PW-1:0] cand,
    output logic          accept
);
    localparam logic [PW-1:0] ONE_BOUND = PW'(1) << N;

    // One pre-shifted copy of the operand per trial bit position.
    logic [PW-1:0] shifted [N];

    for (genvar g = 0; g < N; g++) begin : g_shift
        assign shifted[g] = {{(PW-N){1'b0}}, operand} << g;
    end

    logic [PW-1:0] partial;

    always_comb begin
        partial = '0;
        for (int j = 0; j < N; j++) begin
            if (bit_idx == KW'(j)) partial = shifted[j];
        end
        cand   = prod + partial;
        accept = (cand <= ONE_BOUND);
    end

endmodule

// File: rtl/recip_dp.sv
module recip_dp
    import recip_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned KW = idx_width(N),
    parameter int unsigned PW = prod_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [N-1:0]  value_in,
    input  logic [KW-1:0] bit_idx,
    input  logic [PW-1:0] cand,
    input  logic          accept,
    output logic [N-1:0]  operand,
    output logic [PW-1:0] prod,
    output logic [N-1:0]  approx,
    output logic          zero_flag
);
    typedef struct packed {
        logic [N-1:0]  approx;
        logic [PW-1:0] prod;
    } acc_t;

    acc_t         acc_q;
    logic [N-1:0] opnd_q;
    logic         zero_q;
    logic [N-1:0] trial_bit;

    always_comb trial_bit = N'(1) << bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            opnd_q <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            acc_q  <= '0;
            opnd_q <= value_in;
            zero_q <= (value_in == '0);
        end else if (step && accept) begin
            acc_q.prod   <= cand;
            acc_q.approx <= acc_q.approx | trial_bit;
        end
    end

    always_comb begin
        operand   = opnd_q;
        prod      = acc_q.prod;
        approx    = acc_q.approx;
        zero_flag = zero_q;
    end

endmodule

// File: rtl/recip_unit.sv
module recip_unit
    import recip_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] value_in,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] recip_out,
    output logic         zero_seen
);
    localparam int unsigned KW = idx_width(N);
    localparam int unsigned PW = prod_width(N);

    logic          load_w, step_w, accept_w;
    logic [KW-1:0] idx_w;
    logic [N-1:0]  opnd_w;
    logic [PW-1:0] prod_w, cand_w;

    recip_ctrl #(.N(N), .KW(KW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .load    (load_w),
        .step    (step_w),
        .bit_idx (idx_w)
    );

    recip_step #(.N(N), .KW(KW), .PW(PW)) u_step (
        .operand (opnd_w),
        .prod    (prod_w),
        .bit_idx (idx_w),
        .cand    (cand_w),
        .accept  (accept_w)
    );

    recip_dp #(.N(N), .KW(KW), .PW(PW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .step      (step_w),
        .value_in  (value_in),
        .bit_idx   (idx_w),
        .cand      (cand_w),
        .accept    (accept_w),
        .operand   (opnd_w),
        .prod      (prod_w),
        .approx    (recip_out),
        .zero_flag (zero_seen)
    );

endmodule

// File: rtl/recip_unit_chk.sv
module recip_unit_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 2 * N + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [N-1:0]  recip_out,
    input logic          zero_seen,
    input logic [PW-1:0] prod
);
    localparam logic [PW-1:0] ONE_BOUND = PW'(1) << N;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !zero_seen && recip_out == '0));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    assert_done_follows_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
        (done && zero_seen) |-> (recip_out == '1));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(recip_out) && $stable(zero_seen)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        prod <= ONE_BOUND);

endmodule

bind recip_unit recip_unit_chk #(.N(N), .PW(2 * N + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .recip_out (recip_out),
    .zero_seen (zero_seen),
    .prod      (prod_w)
);

// File: tb/recip_unit_bench.sv
module recip_unit_bench;
    localparam int unsigned N = 8;
    localparam int unsigned ONE = 1 << N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] value_in = '0;
    logic         busy, done, zero_seen;
    logic [N-1:0] recip_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    recip_unit #(.N(N)) u_recip_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .value_in  (value_in),
        .busy      (busy),
        .done      (done),
        .recip_out (recip_out),
        .zero_seen (zero_seen)
    );

    function automatic int unsigned model(input int unsigned v);
        int unsigned q;
        if (v == 0) return ONE - 1;
        q = ONE / v;
        if (q > ONE - 1) q = ONE - 1;
        return q;
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Issue a start, verify busy length and done pulse, return result.
    task automatic run_op(input logic [N-1:0] v, input string req,
                          output logic [N-1:0] res, output logic zf);
        start = 1'b1;
        value_in = v;
        tick();
        start = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (busy !== 1'b1 || done !== 1'b0) begin
                check({req, "/R2 busy window"}, {busy, done}, 2'b10);
            end
            if (c < N - 1) tick();
        end
        tick();
        check({req, "/R3 done pulse"}, {busy, done}, 2'b01);
        res = recip_out;
        zf  = zero_seen;
    endtask

    task automatic test_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", recip_out, 0);
        check("R1 zero flag", zero_seen, 0);
        rst = 1'b0;
        tick();
        check("R1 after release", {busy, done, zero_seen}, 0);
    endtask

    task automatic test_sweep();
        logic [N-1:0] r;
        logic zf;
        for (int v = 1; v < ONE; v++) begin
            run_op(N'(v), "R4", r, zf);
            check("R4 result", r, model(v));
            check("R6 zero flag low", zf, 0);
            check("R9 product bound", ((r * v) <= ONE) ? 1 : 0, 1);
            tick();
            check("R3 done single", done, 0);
        end
    endtask

    task automatic test_pow2();
        logic [N-1:0] r;
        logic zf;
        run_op(N'(1), "R5", r, zf);
        check("R5 v=1", r, ONE - 1);
        tick();
        for (int m = 1; m < N; m++) begin
            run_op(N'(1 << m), "R5", r, zf);
            check("R5 power of two", r, 1 << (N - m));
            tick();
        end
    endtask

    task automatic test_zero();
        logic [N-1:0] r;
        logic zf;
        run_op('0, "R6", r, zf);
        check("R6 zero result", r, ONE - 1);
        check("R6 zero flag", zf, 1);
        tick();
    endtask

    task automatic test_ignore();
        logic [N-1:0] r;
        logic zf;
        start = 1'b1;
        value_in = N'(7);
        tick();
        start = 1'b0;
        tick();
        tick();
        start = 1'b1;          // mid-run start with another operand
        value_in = N'(200);
        tick();
        start = 1'b0;
        for (int c = 0; c < N - 4; c++) tick();
        check("R7 still busy", {busy, done}, 2'b10);
        tick();
        check("R7 done timing", {busy, done}, 2'b01);
        check("R7 result kept", recip_out, model(7));
        start = 1'b1;          // start during the done cycle
        value_in = N'(3);
        tick();
        start = 1'b0;
        check("R7 no run after done", busy, 0);
        tick();
        check("R7 still idle", busy, 0);
        check("R7 result unchanged", recip_out, model(7));
        run_op(N'(9), "R7", r, zf);
        check("R7 next run normal", r, model(9));
        tick();
    endtask

    task automatic test_hold();
        logic [N-1:0] r;
        logic zf;
        run_op('0, "R8", r, zf);
        for (int c = 0; c < 6; c++) begin
            value_in = N'(c * 37 + 5);
            tick();
            check("R8 result hold", recip_out, ONE - 1);
            check("R8 flag hold", zero_seen, 1);
        end
        run_op(N'(5), "R8", r, zf);
        check("R8 new result", r, model(5));
        check("R8 flag cleared", zf, 0);
        value_in = '0;
        tick();
        tick();
        check("R8 hold after run", recip_out, model(5));
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        tick();
        test_reset();
        test_sweep();
        test_pow2();
        test_zero();
        test_ignore();
        test_hold();
        finished = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule